// File: doc/BRIEF.md
# Sequential Restoring Unsigned Divider

A multi-cycle divider for unsigned integers of parameterised width `N` (32 by default). A one-cycle `start` pulse while the block is idle captures a dividend and a divisor. The block then produces one quotient bit per clock cycle by restoring long division, and after `N` cycles it raises `done` for one cycle with the quotient and remainder on its outputs. Those outputs, and the zero-divisor flag, stay unchanged until the next accepted `start`.

One shift register holds both results. Its upper part gathers the partial remainder, with one spare bit above it. Its lower part takes in the dividend and, as the dividend bits shift out, fills with quotient bits. The dividend is loaded already shifted left by one place. In each cycle one subtractor compares the upper part with the divisor. The register then shifts left, inserting the quotient bit, and the upper part takes either the difference or its old value. At the end the remainder is read from the upper part one place to the right of where it was built, which is the final correction shift.

A zero divisor skips the iterations. The block answers on the next clock with `div_by_zero` set, an all-ones quotient and the dividend as the remainder.

Top module: `sr_divider`

## Requirements
- R1: After reset, `busy`, `done` and `div_by_zero` are 0, and `quotient` and `remainder` are 0.
- R2: A `start` sampled while idle with a nonzero divisor sets `busy` at that clock edge. `busy` stays 1 for exactly `N` cycles. `done` is 1 for exactly one cycle, the cycle in which `busy` returns to 0, and is 0 at all other times.
- R3: When `done` is 1 with a nonzero divisor, `quotient` equals floor(dividend / divisor) and `remainder` equals dividend mod divisor. This holds for all operand values, including dividends and divisors at or above 2^(N-1).
- R4: Dividing 7 by 2 gives quotient 3 and remainder 1.
- R5: A `start` sampled while idle with divisor 0 keeps `busy` at 0. At that clock edge it sets `done` for one cycle and sets `div_by_zero`, with `quotient` all ones and `remainder` equal to the dividend.
- R6: A `start` sampled while `busy` is 1 is ignored: the running division keeps its timing and its result.
- R7: While idle with no `start`, `quotient`, `remainder` and `div_by_zero` hold their values. `div_by_zero` returns to 0 only when a `start` with a nonzero divisor is accepted.
- R8: The operands are captured at the accepted `start`. Changes on `dividend` or `divisor` while `busy` is 1 do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division; accepted only while idle |
| dividend | input | N | Unsigned dividend, sampled at an accepted start |
| divisor | input | N | Unsigned divisor, sampled at an accepted start |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse when the results become valid |
| div_by_zero | output | 1 | The last accepted division had a zero divisor |
| quotient | output | N | Quotient, valid from done until the next accepted start |
| remainder | output | N | Remainder, valid from done until the next accepted start |

## Verification
For a nonzero divisor, the results and `done` are due at the `N`th rising edge after the edge that samples `start`. For a zero divisor they are due at the sampling edge itself. The bench model counts the same edges from the same sampled inputs. It updates at each rising edge, and the bench compares `busy`, `done`, `div_by_zero` and, while idle, `quotient` and `remainder` at the following falling edge. The directed checks wait exactly `N` falling edges after lowering `start` (none for a zero divisor) before reading the results, so a latency off by even one cycle shows up as a mismatch.

// File: rtl/sr_divider.sv
module sr_divider #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [N-1:0] dividend,
  input  logic [N-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic         div_by_zero,
  output logic [N-1:0] quotient,
  output logic [N-1:0] remainder
);
  localparam int CW = $clog2(N + 1);

  logic [2*N:0]  acc_q;
  logic [N-1:0]  dvsr_q;
  logic [CW-1:0] left_q;
  logic [N:0]    hi;
  logic [N:0]    trial;
  logic          fits;
  logic [2*N:0]  next_acc;

  assign hi       = acc_q[2*N:N];
  assign trial    = hi - {1'b0, dvsr_q};
  assign fits     = ~trial[N];
  assign next_acc = fits ? {trial[N-1:0], acc_q[N-1:0], 1'b1}
                         : {hi[N-1:0],    acc_q[N-1:0], 1'b0};

  assign quotient  = acc_q[N-1:0];
  assign remainder = acc_q[2*N:N+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q       <= '0;
      dvsr_q      <= '0;
      left_q      <= '0;
      busy        <= 1'b0;
      done        <= 1'b0;
      div_by_zero <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        acc_q  <= next_acc;
        left_q <= left_q - 1'b1;
        if (left_q == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (start) begin
        if (divisor == '0) begin
          acc_q       <= {dividend, 1'b0, {N{1'b1}}};
          div_by_zero <= 1'b1;
          done        <= 1'b1;
        end else begin
          acc_q       <= {{N{1'b0}}, dividend, 1'b0};
          dvsr_q      <= divisor;
          left_q      <= CW'(N);
          busy        <= 1'b1;
          div_by_zero <= 1'b0;
        end
      end
    end
  end
endmodule

module sr_divider_chk #(
  parameter int N = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [N-1:0] divisor,
  input logic         busy,
  input logic         done,
  input logic         div_by_zero,
  input logic [N-1:0] quotient,
  input logic [N-1:0] remainder
);
  logic [N-1:0] seen_dvsr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_dvsr <= '0;
    else if (start && !busy) seen_dvsr <= divisor;
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && divisor != '0) |=> busy); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R2
  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_by_zero) |-> (remainder < seen_dvsr)); // R3
  AST_ZERO_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && divisor == '0) |=> (!busy && done && div_by_zero && quotient == '1)); // R5
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(quotient) && $stable(remainder) && $stable(div_by_zero))); // R7
endmodule

bind sr_divider sr_divider_chk #(.N(N)) u_chk (.*);

// File: tb/tb_sr_divider.sv
module tb_sr_divider;
  localparam int N = 32;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [N-1:0] dividend = '0;
  logic [N-1:0] divisor = '0;
  logic busy, done, div_by_zero;
  logic [N-1:0] quotient, remainder;

  sr_divider #(.N(N)) dut (.*);

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  string phase = "R3";

  // behavioural reference model
  bit m_busy = 0, m_done = 0, m_dz = 0;
  int m_left = 0;
  logic [N-1:0] m_q = '0, m_r = '0, op_a = '0, op_b = '0;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_dz = 0; m_left = 0; m_q = '0; m_r = '0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 0; m_done = 1;
          m_q = op_a / op_b; m_r = op_a % op_b;
        end
      end else if (start) begin
        if (divisor == 0) begin
          m_done = 1; m_dz = 1; m_q = '1; m_r = dividend;
        end else begin
          m_busy = 1; m_left = N; m_dz = 0; op_a = dividend; op_b = divisor;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2", "busy", 64'(busy), 64'(m_busy));
      chk("R2", "done", 64'(done), 64'(m_done));
      chk("R5", "div_by_zero", 64'(div_by_zero), 64'(m_dz));
      if (!m_busy) begin
        chk(phase, "quotient", 64'(quotient), 64'(m_q));
        chk(phase, "remainder", 64'(remainder), 64'(m_r));
      end
    end
  end

  task automatic run(logic [N-1:0] a, logic [N-1:0] b, string req);
    logic [N-1:0] eq, er;
    @(negedge clk);
    start = 1'b1; dividend = a; divisor = b;
    @(negedge clk);
    start = 1'b0;
    if (b != 0) repeat (N) @(negedge clk);
    eq = (b == 0) ? '1 : a / b;
    er = (b == 0) ? a : a % b;
    chk(req, "done at result", 64'(done), 64'd1);
    chk(req, "result quotient", 64'(quotient), 64'(eq));
    chk(req, "result remainder", 64'(remainder), 64'(er));
    chk(req, "result zero flag", 64'(div_by_zero), 64'(b == 0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "busy", 64'(busy), 64'd0);
    chk("R1", "done", 64'(done), 64'd0);
    chk("R1", "div_by_zero", 64'(div_by_zero), 64'd0);
    chk("R1", "quotient", 64'(quotient), 64'd0);
    chk("R1", "remainder", 64'(remainder), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run(32'd7, 32'd2, "R4");
    run(32'd100, 32'd7, "R3");
    run(32'd5, 32'd9, "R3");
    run(32'hFFFF_FFFF, 32'd1, "R3");
    run(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3");
    run(32'hFFFF_FFFF, 32'h8000_0001, "R3");
    run(32'h8000_0000, 32'd3, "R3");
    run(32'hFFFF_FFFE, 32'hC000_0000, "R3");
    run(32'd0, 32'd13, "R3");

    run(32'h1234_5678, 32'd0, "R5");
    phase = "R7";
    repeat (6) @(negedge clk);
    chk("R7", "flag held", 64'(div_by_zero), 64'd1);
    chk("R7", "remainder held", 64'(remainder), 64'h1234_5678);
    run(32'd50, 32'd5, "R7");
    chk("R7", "flag cleared", 64'(div_by_zero), 64'd0);
    repeat (6) @(negedge clk);
    chk("R7", "quotient held", 64'(quotient), 64'd10);
    phase = "R3";

    // R6: second start while busy
    @(negedge clk);
    start = 1'b1; dividend = 32'd1000; divisor = 32'd3;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    start = 1'b1; dividend = 32'd9; divisor = 32'd0;
    @(negedge clk);
    start = 1'b0;
    repeat (N - 5) @(negedge clk);
    chk("R6", "done timing", 64'(done), 64'd1);
    chk("R6", "quotient", 64'(quotient), 64'd333);
    chk("R6", "remainder", 64'(remainder), 64'd1);
    chk("R6", "zero flag", 64'(div_by_zero), 64'd0);

    // R8: operands change while busy
    @(negedge clk);
    start = 1'b1; dividend = 32'hDEAD_BEEF; divisor = 32'd255;
    @(negedge clk);
    start = 1'b0; dividend = 32'd1; divisor = 32'd1;
    repeat (N) @(negedge clk);
    chk("R8", "quotient", 64'(quotient), 64'(32'hDEAD_BEEF / 32'd255));
    chk("R8", "remainder", 64'(remainder), 64'(32'hDEAD_BEEF % 32'd255));

    for (int i = 0; i < 60; i++) begin
      logic [N-1:0] a, b;
      a = $urandom;
      b = $urandom >> ($urandom % 32);
      run(a, b, "R3");
    end

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule